// File: doc/BRIEF.md
# Two-wire serial memory slave front end

This block sits between an open-drain two-wire bus and the storage logic of a 512-byte serial memory. A fast system clock oversamples the clock and data lines through two-flop synchronizers. Edges on the synchronized samples mark the bus clock, and the two line-level conditions that frame every transfer: a start and a stop. After a start the block shifts in a device address byte. It answers only when the byte carries the memory type code and the two strap-selected device bits. The next-to-last bit of that byte picks which of two 256-byte blocks is used.

For a write, the block passes the following word-address byte and each data byte to the write controller as one-cycle strobes, and acknowledges each one. For a read, it asks the address counter for a byte, shifts that byte out MSB first and repeats for as long as the master acknowledges. The bus data line is never driven high: the single output means "pull low". While the external self-timed write is running, the block stays silent on its own address, so a master can poll for completion.

Top module: `twowire_mem_slave`

## Requirements
- R1: A start (data falling while clock high) restarts address reception from any state, including the middle of a byte. A stop (data rising while clock high) returns the block to idle and releases the line. After either condition, an unfinished byte produces no strobe.
- R2: The block acknowledges an address byte only if bits 7..4 equal 1010 and bits 3..2 equal `dev_sel[1:0]`. Any other byte gets no acknowledge, and the block ignores the bus until the next start.
- R3: Address bit 1 is latched onto `blk_sel` when the address is acknowledged. Address bit 0 selects a read when it is 1 and a write when it is 0.
- R4: An acknowledge pulls the line low for the whole ninth bus clock and releases it after the ninth falling edge.
- R5: In a write, the first byte after the address is presented on `waddr` with a one-cycle `waddr_vld`. Each later byte is presented on `wdat` with a one-cycle `wdat_vld`. Every such byte is acknowledged.
- R6: In a read, `rd_req` pulses once per byte. The byte present on `rd_data` is sent MSB first, and the line changes only in the cycle after a synchronized clock falling edge.
- R7: In a read, a master acknowledge on the ninth clock makes the block send the next byte. A not-acknowledge makes it stop driving until the next start.
- R8: While `busy` is high, the block does not acknowledge its own address. Once `busy` is low it does.
- R9: Bus clocks and data seen before any start, after reset, are ignored.
- R10: `sda_oe` is low out of reset. It is never high during a bus-clock high phase that belongs to the master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| dev_sel | input | 2 | Strap value compared with address bits 3..2 |
| busy | input | 1 | Self-timed write in progress |
| sda_oe | output | 1 | High pulls the data line low |
| blk_sel | output | 1 | Block select latched from address bit 1 |
| waddr_vld | output | 1 | One-cycle strobe: word address received |
| waddr | output | 8 | Received word address |
| wdat_vld | output | 1 | One-cycle strobe: data byte received |
| wdat | output | 8 | Received data byte |
| rd_req | output | 1 | One-cycle request for the next read byte |
| rd_data | input | 8 | Read byte, valid the cycle after `rd_req` |
| stop_det | output | 1 | One-cycle pulse on every stop condition |

## Verification
A wrong bit counter or state shows up within one byte time. It appears as a missing or misplaced acknowledge, or as the line pulled low while the master owns the clock-high phase, which the bench watches on every clock. A corrupted shift register shows up at the next strobe as a wrong `waddr` or `wdat`, or as a wrong read byte. A lost master-acknowledge decision shows up in the byte that follows the not-acknowledge.

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
  parameter logic [3:0] DEV_TYPE = 4'b1010,
  parameter int         BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [1:0]        dev_sel,
  input  logic              busy,
  output logic              sda_oe,
  output logic              blk_sel,
  output logic              waddr_vld,
  output logic [BYTE_W-1:0] waddr,
  output logic              wdat_vld,
  output logic [BYTE_W-1:0] wdat,
  output logic              rd_req,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              stop_det
);
  localparam int CW = $clog2(BYTE_W + 2);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W);
  localparam logic [CW-1:0] ACKB = CW'(BYTE_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADDR, S_WDATA, S_READ} st_t;

  logic [2:0]        scl_q, sda_q;
  st_t               st;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sr;
  logic              rnw, mack;

  wire scl_s = scl_q[1], scl_p = scl_q[2];
  wire sda_s = sda_q[1], sda_p = sda_q[2];
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  wire hit      = sr[BYTE_W-1 -: 4] == DEV_TYPE && sr[BYTE_W-5 -: 2] == dev_sel && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sr <= '0; rnw <= 1'b0; mack <= 1'b0;
      sda_oe <= 1'b0; blk_sel <= 1'b0; waddr <= '0; wdat <= '0;
      waddr_vld <= 1'b0; wdat_vld <= 1'b0; rd_req <= 1'b0; stop_det <= 1'b0;
    end else begin
      waddr_vld <= 1'b0;
      wdat_vld  <= 1'b0;
      rd_req    <= 1'b0;
      stop_det  <= 1'b0;
      if (start_c) begin
        st <= S_DEV; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0; stop_det <= 1'b1;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          cnt <= cnt + 1'b1;
          if (st != S_READ && cnt < LAST) sr <= {sr[BYTE_W-2:0], sda_s};
          if (st == S_READ && cnt == LAST) begin
            mack   <= ~sda_s;
            rd_req <= ~sda_s;
          end
        end else if (scl_fall) begin
          if (cnt == LAST) begin
            unique case (st)
              S_DEV: if (hit) begin
                sda_oe <= 1'b1; blk_sel <= sr[1]; rnw <= sr[0]; rd_req <= sr[0];
              end else st <= S_IDLE;
              S_WADDR: begin sda_oe <= 1'b1; waddr_vld <= 1'b1; waddr <= sr; end
              S_WDATA: begin sda_oe <= 1'b1; wdat_vld <= 1'b1; wdat <= sr; end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == ACKB) begin
            cnt <= '0;
            unique case (st)
              S_DEV: if (rnw) begin
                st <= S_READ; sr <= rd_data; sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                st <= S_WADDR; sda_oe <= 1'b0;
              end
              S_READ: if (mack) begin
                sr <= rd_data; sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                st <= S_IDLE; sda_oe <= 1'b0;
              end
              S_WADDR: begin st <= S_WDATA; sda_oe <= 1'b0; end
              default: sda_oe <= 1'b0;
            endcase
          end else if (st == S_READ && cnt != '0) begin
            sda_oe <= ~sr[BYTE_W-2];
            sr     <= {sr[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assert_oe_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
  assert_release_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall | start_c | stop_c));
  assert_ack_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && $past(st == S_DEV)) |->
      ($past(sr[BYTE_W-1 -: 4]) == DEV_TYPE && $past(sr[BYTE_W-5 -: 2]) == $past(dev_sel)));
  assert_busy_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && $past(st == S_DEV)) |-> !$past(busy));
  assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |-> (!sda_oe && st == S_IDLE));
  assert_strobe_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (waddr_vld | wdat_vld) |-> sda_oe);
endmodule

// File: tb/twowire_mem_slave_bench.sv
module twowire_mem_slave_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_low = 1'b0, slot = 1'b0;
  logic [1:0] dev_sel = 2'b10;
  logic sda_oe, blk_sel, waddr_vld, wdat_vld, rd_req, stop_det;
  logic [7:0] waddr, wdat, rd_data;
  logic busy;
  wire sda_bus = !(m_low || sda_oe);

  twowire_mem_slave u_twowire_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus), .dev_sel(dev_sel),
    .busy(busy), .sda_oe(sda_oe), .blk_sel(blk_sel), .waddr_vld(waddr_vld),
    .waddr(waddr), .wdat_vld(wdat_vld), .wdat(wdat), .rd_req(rd_req),
    .rd_data(rd_data), .stop_det(stop_det));

  int tests = 0, fails = 0, viol = 0;
  logic [7:0] gold [512];
  logic [7:0] mem [512];
  logic [8:0] ptr, pa [32];
  logic [7:0] pd [32];
  int npend, busy_cnt;
  logic [7:0] exp_wa [$];
  logic [7:0] exp_wd [$];

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  assign busy = busy_cnt != 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0; busy_cnt <= 0; npend <= 0; rd_data <= '0;
      for (int i = 0; i < 512; i++) mem[i] <= init_val(i);
    end else begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (waddr_vld) ptr <= {blk_sel, waddr};
      if (wdat_vld) begin
        pa[npend] <= ptr; pd[npend] <= wdat; npend <= npend + 1;
        ptr <= {ptr[8:4], ptr[3:0] + 4'd1};
      end
      if (rd_req) begin rd_data <= mem[ptr]; ptr <= ptr + 9'd1; end
      if (stop_det && npend != 0) begin
        for (int k = 0; k < npend; k++) mem[pa[k]] <= pd[k];
        npend <= 0; busy_cnt <= 3000;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (m_scl && !slot && sda_oe) viol++;
    if (waddr_vld) begin
      if (exp_wa.size() == 0) check(0, "R5 unexpected waddr", waddr, 0);
      else begin
        logic [7:0] e;
        e = exp_wa.pop_front();
        check(waddr == e, "R5 waddr", waddr, e);
      end
    end
    if (wdat_vld) begin
      if (exp_wd.size() == 0) check(0, "R5 unexpected wdat", wdat, 0);
      else begin
        logic [7:0] e;
        e = exp_wd.pop_front();
        check(wdat == e, "R5 wdat", wdat, e);
      end
    end
  end

  task automatic bit_slot(input logic v, input logic sl, output logic seen);
    slot = sl;
    repeat (8) @(negedge clk);
    m_low = ~v;
    repeat (12) @(negedge clk);
    m_scl = 1'b1;
    repeat (10) @(negedge clk);
    seen = sda_bus;
    repeat (10) @(negedge clk);
    m_scl = 1'b0;
  endtask

  task automatic bus_start();
    slot = 1'b0;
    repeat (4) @(negedge clk);
    m_low = 1'b0;
    repeat (10) @(negedge clk);
    m_scl = 1'b1;
    repeat (10) @(negedge clk);
    m_low = 1'b1;
    repeat (10) @(negedge clk);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    slot = 1'b0;
    repeat (8) @(negedge clk);
    m_low = 1'b1;
    repeat (10) @(negedge clk);
    m_scl = 1'b1;
    repeat (10) @(negedge clk);
    m_low = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_slot(b[i], 1'b0, s);
    bit_slot(1'b1, 1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_slot(1'b1, 1'b1, s);
      d[i] = s;
    end
    bit_slot(~mack, 1'b0, s);
  endtask

  task automatic wait_ready();
    logic a;
    a = 1'b0;
    for (int n = 0; n < 30 && !a; n++) begin
      bus_start();
      send_byte({4'b1010, dev_sel, 2'b00}, a);
      bus_stop();
    end
    check(a, "R8 ready after busy", a, 1);
  endtask

  task automatic set_addr(input logic p, input logic [7:0] wa);
    logic a;
    bus_start();
    send_byte({4'b1010, dev_sel, p, 1'b0}, a);
    check(a, "R2 address ack", a, 1);
    exp_wa.push_back(wa);
    send_byte(wa, a);
    check(a, "R5 word address ack", a, 1);
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < 512; i++) gold[i] = init_val(i);
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R10 reset drive", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    m_scl = 1'b0;
    send_byte({4'b1010, dev_sel, 2'b00}, a);
    check(!a, "R9 no ack before start", a, 0);
    bus_stop();

    bus_start();
    send_byte({4'b1010, 2'b01, 2'b00}, a);
    check(!a, "R2 device bits mismatch", a, 0);
    send_byte(8'h00, a);
    check(!a, "R2 ignored after mismatch", a, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, dev_sel, 2'b00}, a);
    check(!a, "R2 type mismatch", a, 0);
    bus_stop();

    set_addr(1'b1, 8'h34);
    check(blk_sel == 1'b1, "R3 block select", blk_sel, 1);
    exp_wd.push_back(8'hA5);
    send_byte(8'hA5, a);
    check(a, "R4 data ack", a, 1);
    bus_stop();
    gold[9'h134] = 8'hA5;
    check(busy == 1'b1, "R1 stop ends write", busy, 1);

    bus_start();
    send_byte({4'b1010, dev_sel, 2'b00}, a);
    check(!a, "R8 silent while busy", a, 0);
    bus_stop();
    wait_ready();

    set_addr(1'b1, 8'h34);
    bus_start();
    send_byte({4'b1010, dev_sel, 2'b11}, a);
    check(a, "R1 repeated start read ack", a, 1);
    recv_byte(1'b0, d);
    check(d == gold[9'h134], "R6 random read", d, gold[9'h134]);
    bus_stop();

    set_addr(1'b0, 8'h0E);
    exp_wd.push_back(8'h11); exp_wd.push_back(8'h22);
    exp_wd.push_back(8'h33); exp_wd.push_back(8'h44);
    send_byte(8'h11, a); check(a, "R5 page byte ack", a, 1);
    send_byte(8'h22, a); check(a, "R5 page byte ack", a, 1);
    send_byte(8'h33, a); check(a, "R5 page byte ack", a, 1);
    send_byte(8'h44, a); check(a, "R5 page byte ack", a, 1);
    bus_stop();
    gold[9'h00E] = 8'h11; gold[9'h00F] = 8'h22; gold[9'h000] = 8'h33; gold[9'h001] = 8'h44;
    wait_ready();

    set_addr(1'b0, 8'h0E);
    bus_start();
    send_byte({4'b1010, dev_sel, 2'b01}, a);
    recv_byte(1'b1, d); check(d == gold[9'h00E], "R7 sequential byte 0", d, gold[9'h00E]);
    recv_byte(1'b1, d); check(d == gold[9'h00F], "R7 sequential byte 1", d, gold[9'h00F]);
    recv_byte(1'b0, d); check(d == gold[9'h010], "R7 sequential byte 2", d, gold[9'h010]);
    recv_byte(1'b0, d); check(d == 8'hFF, "R7 silent after nack", d, 8'hFF);
    bus_stop();

    bus_start();
    send_byte({4'b1010, dev_sel, 2'b01}, a);
    recv_byte(1'b0, d); check(d == gold[9'h011], "R6 current address read", d, gold[9'h011]);
    bus_stop();

    set_addr(1'b0, 8'h00);
    bus_start();
    send_byte({4'b1010, dev_sel, 2'b01}, a);
    recv_byte(1'b1, d); check(d == gold[9'h000], "R6 wrapped page byte", d, gold[9'h000]);
    recv_byte(1'b0, d); check(d == gold[9'h001], "R6 wrapped page byte", d, gold[9'h001]);
    bus_stop();

    set_addr(1'b0, 8'h50);
    bit_slot(1'b1, 1'b0, a); bit_slot(1'b0, 1'b0, a); bit_slot(1'b1, 1'b0, a);
    bus_start();
    send_byte({4'b1010, dev_sel, 2'b01}, a);
    check(a, "R1 start mid byte", a, 1);
    recv_byte(1'b0, d); check(d == gold[9'h050], "R1 read after restart", d, gold[9'h050]);
    bus_stop();
    check(busy == 1'b0, "R1 partial byte dropped", busy, 0);

    check(viol == 0, "R10 drive in master phase", viol, 0);
    check(exp_wa.size() == 0 && exp_wd.size() == 0, "R5 all strobes seen",
          exp_wa.size() + exp_wd.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule